// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block produces the host interrupt of a real-time clock. A free-running tick counter advances once for each 32.768 kHz enable. Two periodic sources act on bit 4 of an eight-bit interrupt flag register. The first is a raw pulse mode that sets and clears the bit on every tick. The second is a steady mode whose level follows a mask over tick-counter bits 14 to 10, picked by a five-bit frequency select. Each bit raised in the flag register is also latched into status register 1, which keeps it after the flag clears.

The host line pulses only when flag bits 5:4 go from both clear to at least one set. It also needs the host port-control word to hold the enable pattern. Other clock functions (alarms, command handling) raise or clear flags through the explicit set and clear inputs. The whole block runs in one synchronous clock domain, and the tick input acts as a clock enable.

Top module: `rtc_irq_gen`

## Requirements
- R1: After reset the flag register, status register 1, the tick counter and `host_irq_o` are all zero.
- R2: The tick counter (15 bits) adds one on each clock with `tick_i` high and holds otherwise. It wraps from 0x7FFF to 0.
- R3: Pulse mode is selected by `ctrl2_i` bit 3. On a tick in this mode, flag bit 4 (0x10) counts as raised for edge detection and is latched into status register 1. The flag bit itself ends the tick cleared.
- R4: Steady mode is selected by `ctrl2_i` bits 1:0 equal to 01 with bit 3 clear. Select bit i (i = 0 to 4) enables counter bit 14 − i. On a tick, flag bit 4 is set if the mask is nonzero and the post-increment count ANDed with the mask differs from the mask. Otherwise flag bit 4 is cleared.
- R5: When `ctrl2_i` bit 3 and bits 1:0 = 01 are both present, pulse mode applies.
- R6: A tick with neither mode selected leaves the flag register unchanged.
- R7: `host_irq_o` is high for one cycle, in the cycle after the clock edge at which flag bits 5:4 go from 00 to nonzero.
- R8: Raising a flag while flag bits 5:4 are already nonzero produces no host pulse.
- R9: A host pulse requires `port_ctrl_i & 0xC100 == 0x8100` in the triggering cycle.
- R10: `flag_set_i` ORs into the flags and status register 1. `flag_clr_i` clears flags only, and it wins over a set of the same bit in the same cycle. Status register 1 never loses a bit until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz tick enable |
| ctrl2_i | input | 8 | Status register 2 (bit 3 pulse mode, bits 1:0 steady select) |
| freq_sel_i | input | 5 | Steady-mode frequency select |
| port_ctrl_i | input | 16 | Host port-control word |
| flag_set_i | input | 8 | Flag bits to raise this cycle |
| flag_clr_i | input | 8 | Flag bits to clear this cycle |
| flags_o | output | 8 | Interrupt flag register |
| stat1_o | output | 8 | Status register 1 |
| host_irq_o | output | 1 | Host interrupt pulse |
| tick_cnt_o | output | 15 | Tick counter |

## Verification
The flags, status register 1, the counter and the host pulse all update at the clock edge that samples the stimulus. All four are therefore due one cycle after the inputs are driven. The driver applies inputs on the falling edge and queues the expected values of all four outputs. The monitor compares them 1 ns after the next rising edge. The bench never looks at a later or earlier cycle, so a late or stretched host pulse shows up as a mismatch.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned FLAG_W       = 8;
  localparam int unsigned PERIODIC_BIT = 4;
  localparam logic [FLAG_W-1:0] HOST_SRC_MASK = 8'h30;
  localparam logic [15:0] PC_MASK  = 16'hC100;
  localparam logic [15:0] PC_MATCH = 16'h8100;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_PULSE  = 2'd1,
    MODE_STEADY = 2'd2
  } irq_mode_e;

  typedef struct packed {
    logic set;
    logic clr;
  } src_req_t;
endpackage

// File: rtl/rtc_irq_tick_cnt.sv
module rtc_irq_tick_cnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = tick_i ? cnt_q + 1'b1 : cnt_q;
  assign cnt_q_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/rtc_irq_src.sv
module rtc_irq_src
  import rtc_irq_pkg::*;
#(
  parameter int unsigned SEL_W = 5
) (
  input  logic             tick_i,
  input  logic [7:0]       ctrl2_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] cnt_slice_i,  // counter bits TOP..LO, MSB first
  output src_req_t         req_o
);
  irq_mode_e        mode;
  logic [SEL_W-1:0] field;
  logic             steady_lvl;

  // select bit i gates the i-th counter bit counted down from the top
  for (genvar i = 0; i < SEL_W; i++) begin : g_map
    assign field[SEL_W-1-i] = sel_i[i];
  end

  always_comb begin
    if ((ctrl2_i & 8'h08) != 8'h00)      mode = MODE_PULSE;
    else if ((ctrl2_i & 8'h03) == 8'h01) mode = MODE_STEADY;
    else                                 mode = MODE_NONE;
  end

  assign steady_lvl = (|field) && ((cnt_slice_i & field) != field);

  always_comb begin
    req_o = '0;
    if (tick_i) begin
      unique case (mode)
        MODE_PULSE:  begin req_o.set = 1'b1;       req_o.clr = 1'b1;        end
        MODE_STEADY: begin req_o.set = steady_lvl; req_o.clr = ~steady_lvl; end
        default:     req_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_req_t          req_i,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic [15:0]       port_ctrl_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] stat1_o,
  output logic              host_irq_o
);
  localparam logic [FLAG_W-1:0] PER_BIT = FLAG_W'(1) << PERIODIC_BIT;

  logic [FLAG_W-1:0] flags_q, stat1_q, set_all, clr_all, raised;
  logic              rise, gate_ok, irq_q;

  assign set_all = set_i | (req_i.set ? PER_BIT : '0);
  assign clr_all = clr_i | (req_i.clr ? PER_BIT : '0);
  assign raised  = flags_q | set_all;
  // edge taken on the raised value, before same-cycle clears
  assign rise    = ((flags_q & HOST_SRC_MASK) == '0) && ((raised & HOST_SRC_MASK) != '0);
  assign gate_ok = (port_ctrl_i & PC_MASK) == PC_MATCH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      stat1_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= raised & ~clr_all;
      stat1_q <= stat1_q | set_all;
      irq_q   <= rise & gate_ok;
    end
  end

  assign flags_o    = flags_q;
  assign stat1_o    = stat1_q;
  assign host_irq_o = irq_q;
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
  import rtc_irq_pkg::*;
#(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned TOP_BIT = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [7:0]       ctrl2_i,
  input  logic [SEL_W-1:0] freq_sel_i,
  input  logic [15:0]      port_ctrl_i,
  input  logic [7:0]       flag_set_i,
  input  logic [7:0]       flag_clr_i,
  output logic [7:0]       flags_o,
  output logic [7:0]       stat1_o,
  output logic             host_irq_o,
  output logic [CNT_W-1:0] tick_cnt_o
);
  localparam int unsigned LO_BIT = TOP_BIT - SEL_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  src_req_t         req;

  rtc_irq_tick_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cnt_q_o   (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  rtc_irq_src #(.SEL_W(SEL_W)) i_src (
    .tick_i      (tick_i),
    .ctrl2_i     (ctrl2_i),
    .sel_i       (freq_sel_i),
    .cnt_slice_i (cnt_nxt[TOP_BIT:LO_BIT]),
    .req_o       (req)
  );

  rtc_irq_flags i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .set_i       (flag_set_i),
    .clr_i       (flag_clr_i),
    .port_ctrl_i (port_ctrl_i),
    .flags_o     (flags_o),
    .stat1_o     (stat1_o),
    .host_irq_o  (host_irq_o)
  );

  assign tick_cnt_o = cnt_q;
endmodule

// File: rtl/rtc_irq_gen_chk.sv
module rtc_irq_gen_chk #(
  parameter int unsigned CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [7:0]       ctrl2_i,
  input logic [15:0]      port_ctrl_i,
  input logic [7:0]       flag_set_i,
  input logic [7:0]       flag_clr_i,
  input logic [7:0]       flags_o,
  input logic [7:0]       stat1_o,
  input logic             host_irq_o,
  input logic [CNT_W-1:0] tick_cnt_o
);
  a_r2_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tick_cnt_o));

  a_r2_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> tick_cnt_o == CNT_W'($past(tick_cnt_o) + 1'b1));

  a_r3_pulse_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ctrl2_i[3]) |=> (!flags_o[4] && stat1_o[4]));

  a_r6_no_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl2_i[3] && ctrl2_i[1:0] != 2'b01 && flag_set_i == '0 && flag_clr_i == '0)
      |=> $stable(flags_o));

  a_r8_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> ($past(flags_o[5:4]) == 2'b00 && stat1_o[5:4] != 2'b00));

  a_r9_port_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> $past((port_ctrl_i & 16'hC100) == 16'h8100));

  a_r10_stat1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat1_o & $past(stat1_o)) == $past(stat1_o)));
endmodule

bind rtc_irq_gen rtc_irq_gen_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .ctrl2_i     (ctrl2_i),
  .port_ctrl_i (port_ctrl_i),
  .flag_set_i  (flag_set_i),
  .flag_clr_i  (flag_clr_i),
  .flags_o     (flags_o),
  .stat1_o     (stat1_o),
  .host_irq_o  (host_irq_o),
  .tick_cnt_o  (tick_cnt_o)
);

// File: tb/test_rtc_irq_gen.sv
module test_rtc_irq_gen;
  localparam int unsigned CNT_W = 15;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick_i = 1'b0;
  logic [7:0]       ctrl2_i = '0;
  logic [4:0]       freq_sel_i = '0;
  logic [15:0]      port_ctrl_i = '0;
  logic [7:0]       flag_set_i = '0;
  logic [7:0]       flag_clr_i = '0;
  logic [7:0]       flags_o, stat1_o;
  logic             host_irq_o;
  logic [CNT_W-1:0] tick_cnt_o;

  rtc_irq_gen i_rtc_irq_gen (.*);

  always #2 clk_i = ~clk_i;  // 250 MHz

  typedef struct {
    logic [7:0]       flags;
    logic [7:0]       stat1;
    logic             irq;
    logic [CNT_W-1:0] cnt;
    string            tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  logic [7:0]       m_flags = '0, m_stat1 = '0;
  logic [CNT_W-1:0] m_cnt = '0;

  task automatic step(input logic t, input logic [7:0] c2, input logic [4:0] sel,
                      input logic [15:0] pc, input logic [7:0] st, input logic [7:0] cl,
                      input string tag);
    logic [CNT_W-1:0] nc;
    logic [14:0]      mask;
    logic             tset, tclr, lvl, rise;
    logic [7:0]       setv, clrv;
    exp_t             e;
    @(negedge clk_i);
    tick_i = t; ctrl2_i = c2; freq_sel_i = sel; port_ctrl_i = pc;
    flag_set_i = st; flag_clr_i = cl;
    nc = t ? m_cnt + 1'b1 : m_cnt;
    tset = 1'b0; tclr = 1'b0;
    if (t) begin
      if (c2[3]) begin
        tset = 1'b1; tclr = 1'b1;
      end else if (c2[1:0] == 2'b01) begin
        mask = {sel[0], sel[1], sel[2], sel[3], sel[4], 10'b0};
        lvl  = (mask != 0) && ((nc & mask) != mask);
        tset = lvl; tclr = !lvl;
      end
    end
    setv = st | (tset ? 8'h10 : 8'h00);
    clrv = cl | (tclr ? 8'h10 : 8'h00);
    rise = ((m_flags & 8'h30) == 0) && (((m_flags | setv) & 8'h30) != 0);
    e.irq   = rise && ((pc & 16'hC100) == 16'h8100);
    m_flags = (m_flags | setv) & ~clrv;
    m_stat1 = m_stat1 | setv;
    m_cnt   = nc;
    e.flags = m_flags; e.stat1 = m_stat1; e.cnt = m_cnt;
    e.tag   = (t && m_cnt == 0) ? "R2 wrap" : tag;
    q.push_back(e);
  endtask

  // monitor: results due one edge after drive
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (flags_o !== e.flags || stat1_o !== e.stat1 || host_irq_o !== e.irq ||
          tick_cnt_o !== e.cnt) begin
        n_fail++;
        $display("FAIL %s: flags=%h stat1=%h irq=%b cnt=%h exp flags=%h stat1=%h irq=%b cnt=%h",
                 e.tag, flags_o, stat1_o, host_irq_o, tick_cnt_o,
                 e.flags, e.stat1, e.irq, e.cnt);
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] sels [9];
    sels = '{5'h01, 5'h10, 5'h00, 5'h1F, 5'h02, 5'h08, 5'h04, 5'h05, 5'h1F};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 8'h00, 5'h00, 16'h8100, 8'h00, 8'h00, "R1 reset");
    step(1, 8'h00, 5'h00, 16'h8100, 8'h00, 8'h00, "R2 R6 no mode");
    step(1, 8'h04, 5'h1F, 16'h8100, 8'h00, 8'h00, "R6 no mode");
    step(0, 8'h00, 5'h00, 16'h8100, 8'h00, 8'h00, "R2 hold");
    step(0, 8'h00, 5'h00, 16'h8100, 8'h01, 8'h00, "R10 set");
    step(1, 8'h02, 5'h00, 16'h8100, 8'h00, 8'h00, "R6 keep");
    step(1, 8'h08, 5'h00, 16'h8100, 8'h00, 8'h00, "R3 R7 pulse");
    step(0, 8'h08, 5'h00, 16'h8100, 8'h00, 8'h00, "R7 one cycle");
    step(1, 8'h08, 5'h00, 16'h8100, 8'h00, 8'h00, "R3 again");
    step(1, 8'h09, 5'h00, 16'h8100, 8'h00, 8'h00, "R5 priority");
    step(0, 8'h00, 5'h00, 16'h8100, 8'h20, 8'h00, "R7 ext set");
    step(1, 8'h08, 5'h00, 16'h8100, 8'h00, 8'h00, "R8 no retrigger");
    step(0, 8'h00, 5'h00, 16'h8100, 8'h02, 8'h22, "R10 clear wins");
    step(1, 8'h08, 5'h00, 16'hC100, 8'h00, 8'h00, "R9 blocked C100");
    step(1, 8'h08, 5'h00, 16'h0100, 8'h00, 8'h00, "R9 blocked 0100");
    step(1, 8'h08, 5'h00, 16'h8000, 8'h00, 8'h00, "R9 blocked 8000");
    step(1, 8'h08, 5'h00, 16'h81FF, 8'h00, 8'h00, "R9 open 81FF");
    for (int k = 0; k < 34000; k++)
      step(1, 8'h01, sels[k / 4096], 16'h8100, 8'h00, 8'h00, "R4 steady");
    step(1, 8'h02, 5'h1F, 16'h8100, 8'h00, 8'h00, "R6 after steady");
    step(0, 8'h00, 5'h00, 16'h8100, 8'h00, 8'h00, "R10 final");
    @(posedge clk_i); #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule